// File: doc/BRIEF.md
# Vector Byte Window Extractor

This block executes the vector byte-window extract operation of a SIMD pipeline. It receives a 32-bit instruction word with a valid strobe and two 128-bit operand values already read from the register file: the first source and the second source. It joins the two operands, with the first source in the low bytes, and returns a window of bytes from that joined value. The window starts at a 4-bit byte index carried in the instruction. A width bit chooses between a 16-byte and an 8-byte vector.

The same upper encoding also carries an element-move instruction, which this block does not execute. Bit 10 tells the two apart. A parameter sets whether this unit is the only decoder for that encoding. When it is, an element-move word raises the undefined flag. When another unit owns element-move, such a word is ignored here without any effect. Every result is registered and appears one cycle after the valid strobe.

Top module: `byte_window_extract`

## Requirements
- R1: A word is claimed only when `instrValid` is 1, bit 31 is 0 and bits 29:21 equal 9'b1_0111_0000, so that bits 31:21 read 0x370 when bit 30 is 1. Bit 15 must also be 0. A word that is not claimed never raises `wrEn` or `undefFlag`, and it leaves `resultData` and `dstIdx` unchanged.
- R2: Bits 4:0 give the destination index, reported on `dstIdx` with the result. Bits 14:11 give the start byte index. Bit 30 selects full width (1, 16 bytes) or half width (0, 8 bytes). Bit 10 set to 0 selects extract.
- R3: In full width, result byte j (bits 8j+7:8j) equals first-source byte j+idx when j+idx < 16. Otherwise it equals second-source byte j+idx-16.
- R4: In half width, result byte j for j < 8 equals first-source byte j+idx when j+idx < 8. Otherwise it equals second-source byte j+idx-8. Result bits 127:64 are zero.
- R5: A start index of 0 returns the first source unchanged over the active width.
- R6: In half width, a start index with bit 3 set (instruction bit 14) raises `undefFlag` and writes nothing.
- R7: A claimed word with bit 10 set never writes. It raises `undefFlag` only when SOLE_DECODER is 1.
- R8: Outputs are registered. `wrEn` and `undefFlag` are pulses for the cycle after the valid word, and both are 0 in any cycle that follows a cycle with `instrValid` at 0.
- R9: After reset, `wrEn`, `undefFlag`, `resultData` and `dstIdx` are all 0.
- R10: `wrEn` and `undefFlag` are never 1 together. A word that does not write leaves `resultData` and `dstIdx` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word |
| srcFirst | input | 128 | First source operand (low half of the joined value) |
| srcSecond | input | 128 | Second source operand (high half of the joined value) |
| dstIdx | output | 5 | Destination register index of the last write |
| resultData | output | 128 | Extracted byte window |
| wrEn | output | 1 | Result write pulse |
| undefFlag | output | 1 | Undefined-instruction pulse |

## Verification
The bench builds two copies at the default 16-byte vector with 8-bit bytes: one with SOLE_DECODER set to 1 and one with it set to 0. Both copies take the same stimulus, so the bit-10 rule is checked under both settings in a single run. At this size the bench can sweep every start index under both widths for three operand patterns. That sweep reaches every crossover point between the two sources, every illegal half-width index, and the identity case at index 0. Other words follow: non-claimed words, words with bit 15 set and idle cycles. Each of these is checked against the result held from before.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

  localparam logic       FAM_BIT31  = 1'b0;
  localparam logic [8:0] FAM_29_21  = 9'b1_0111_0000;
  localparam int         IDX_W      = 4;
  localparam int         REG_W      = 5;

  typedef struct packed {
    logic             doWrite;
    logic             raiseUndef;
    logic             fullWidth;
    logic [IDX_W-1:0] startIdx;
    logic [REG_W-1:0] dstReg;
  } bwx_ctrl_t;

endpackage

// File: rtl/bwx_decode.sv
module bwx_decode
  import bwx_pkg::*;
#(
  parameter bit SOLE_DECODER = 1'b1
) (
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  output bwx_ctrl_t   ctrlStrobes
);

  logic isFamily;
  logic isMove;
  logic fullW;
  logic badIdx;
  logic [IDX_W-1:0] idxField;
  logic unusedRegFields;

  // Source register numbers are resolved before this block; they are not needed here.
  assign unusedRegFields = ^{instrWord[20:16], instrWord[9:5]};

  always_comb begin
    // Bit 30 is the width bit, so it is left out of the family match.
    isFamily = instrValid
             && (instrWord[31] == FAM_BIT31)
             && (instrWord[29:21] == FAM_29_21)
             && !instrWord[15];
    isMove   = instrWord[10];
    fullW    = instrWord[30];
    idxField = instrWord[14:11];
    badIdx   = !fullW && idxField[IDX_W-1];

    ctrlStrobes.doWrite    = isFamily && !isMove && !badIdx;
    ctrlStrobes.raiseUndef = isFamily && (isMove ? SOLE_DECODER : badIdx);
    ctrlStrobes.fullWidth  = fullW;
    ctrlStrobes.startIdx   = idxField;
    ctrlStrobes.dstReg     = instrWord[4:0];
  end

endmodule

// File: rtl/bwx_datapath.sv
module bwx_datapath
  import bwx_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int BYTE_W    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bwx_ctrl_t                ctrlStrobes,
  input  logic [VEC_BYTES*BYTE_W-1:0] srcFirst,
  input  logic [VEC_BYTES*BYTE_W-1:0] srcSecond,
  output logic [REG_W-1:0]         dstIdx,
  output logic [VEC_BYTES*BYTE_W-1:0] resultData,
  output logic                     wrEn,
  output logic                     undefFlag
);

  localparam int VEC_W      = VEC_BYTES * BYTE_W;
  localparam int HALF_BYTES = VEC_BYTES / 2;
  localparam int HALF_W     = HALF_BYTES * BYTE_W;

  logic [31:0]        shiftBits;
  logic [2*VEC_W-1:0] fullCat;
  logic [VEC_W-1:0]   halfCat;
  logic [VEC_W-1:0]   fullWin;
  logic [HALF_W-1:0]  halfWin;
  logic [VEC_W-1:0]   nextResult;

  assign shiftBits = 32'(ctrlStrobes.startIdx) * BYTE_W;
  assign fullCat   = {srcSecond, srcFirst};
  assign halfCat   = {srcSecond[HALF_W-1:0], srcFirst[HALF_W-1:0]};
  assign fullWin   = VEC_W'(fullCat >> shiftBits);
  assign halfWin   = HALF_W'(halfCat >> shiftBits);

  // Per-lane select: low lanes come from either window, high lanes zero in half width.
  for (genvar lane = 0; lane < VEC_BYTES; lane++) begin : g_lane
    if (lane < HALF_BYTES) begin : g_low
      assign nextResult[lane*BYTE_W +: BYTE_W] = ctrlStrobes.fullWidth
        ? fullWin[lane*BYTE_W +: BYTE_W] : halfWin[lane*BYTE_W +: BYTE_W];
    end else begin : g_high
      assign nextResult[lane*BYTE_W +: BYTE_W] = ctrlStrobes.fullWidth
        ? fullWin[lane*BYTE_W +: BYTE_W] : {BYTE_W{1'b0}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrEn       <= 1'b0;
      undefFlag  <= 1'b0;
      dstIdx     <= '0;
      resultData <= '0;
    end else begin
      wrEn      <= ctrlStrobes.doWrite;
      undefFlag <= ctrlStrobes.raiseUndef;
      if (ctrlStrobes.doWrite) begin
        dstIdx     <= ctrlStrobes.dstReg;
        resultData <= nextResult;
      end
    end
  end

  // R10: write and undefined pulses are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && undefFlag));

  // R10: a cycle without a write leaves the result and index alone
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlStrobes.doWrite |=> ($stable(resultData) && $stable(dstIdx)));

endmodule

// File: rtl/byte_window_extract.sv
module byte_window_extract
  import bwx_pkg::*;
#(
  parameter int VEC_BYTES    = 16,
  parameter int BYTE_W       = 8,
  parameter bit SOLE_DECODER = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          instrValid,
  input  logic [31:0]                   instrWord,
  input  logic [VEC_BYTES*BYTE_W-1:0]   srcFirst,
  input  logic [VEC_BYTES*BYTE_W-1:0]   srcSecond,
  output logic [REG_W-1:0]              dstIdx,
  output logic [VEC_BYTES*BYTE_W-1:0]   resultData,
  output logic                          wrEn,
  output logic                          undefFlag
);

  localparam int HALF_W = VEC_BYTES * BYTE_W / 2;

  bwx_ctrl_t ctrlStrobes;

  bwx_decode #(.SOLE_DECODER(SOLE_DECODER)) decode_i (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .ctrlStrobes(ctrlStrobes)
  );

  bwx_datapath #(.VEC_BYTES(VEC_BYTES), .BYTE_W(BYTE_W)) datapath_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlStrobes(ctrlStrobes),
    .srcFirst   (srcFirst),
    .srcSecond  (srcSecond),
    .dstIdx     (dstIdx),
    .resultData (resultData),
    .wrEn       (wrEn),
    .undefFlag  (undefFlag)
  );

  logic famWord;
  assign famWord = instrValid && !instrWord[31] && (instrWord[29:21] == FAM_29_21) && !instrWord[15];

  // R8: no pulse after an idle cycle
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !instrValid |=> (!wrEn && !undefFlag));

  // R6: half width with index bit 3 set is undefined
  a_r6_half_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (famWord && !instrWord[10] && !instrWord[30] && instrWord[14]) |=> (undefFlag && !wrEn));

  // R4: half-width write clears the upper half
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (famWord && !instrWord[10] && !instrWord[30] && !instrWord[14])
      |=> (wrEn && (resultData[2*HALF_W-1:HALF_W] == '0)));

  // R5: full width with index 0 copies the first source
  a_r5_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (famWord && !instrWord[10] && instrWord[30] && (instrWord[14:11] == 4'd0))
      |=> (wrEn && (resultData == $past(srcFirst))));

  // R7: element-move words never write; undefined only as sole decoder
  a_r7_move_word: assert property (@(posedge clk) disable iff (!rst_n)
    (famWord && instrWord[10]) |=> (!wrEn && (undefFlag == SOLE_DECODER)));

endmodule

// File: tb/byte_window_extract_tb_top.sv
module byte_window_extract_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         instrValid = 1'b0;
  logic [31:0]  instrWord = '0;
  logic [127:0] srcFirst = '0;
  logic [127:0] srcSecond = '0;

  logic [4:0]   dstIdx, shDstIdx;
  logic [127:0] resultData, shResult;
  logic         wrEn, shWrEn, undefFlag, shUndef;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [127:0] lastRes;
  logic [4:0]   lastRd;

  always #2.5 clk = ~clk;

  byte_window_extract #(.SOLE_DECODER(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .instrWord(instrWord),
    .srcFirst(srcFirst), .srcSecond(srcSecond), .dstIdx(dstIdx),
    .resultData(resultData), .wrEn(wrEn), .undefFlag(undefFlag));

  byte_window_extract #(.SOLE_DECODER(1'b0)) dutShared_i (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .instrWord(instrWord),
    .srcFirst(srcFirst), .srcSecond(srcSecond), .dstIdx(shDstIdx),
    .resultData(shResult), .wrEn(shWrEn), .undefFlag(shUndef));

  function automatic logic [31:0] mkWord(logic full, logic [3:0] idx, logic [4:0] rd,
                                         logic b10, logic b15, logic b31);
    return {b31, full, 9'b1_0111_0000, 5'd7, b15, idx, b10, 5'd3, rd};
  endfunction

  function automatic logic [127:0] expWin(logic [127:0] a, logic [127:0] b,
                                          logic full, int idx);
    logic [127:0] r = '0;
    int lim = full ? 16 : 8;
    for (int j = 0; j < lim; j++) begin
      int k = j + idx;
      if (k < lim) r[j*8 +: 8] = a[k*8 +: 8];
      else         r[j*8 +: 8] = b[(k-lim)*8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [127:0] mkPat(int p, int sel);
    logic [127:0] v;
    for (int k = 0; k < 16; k++) begin
      if (p == 0) v[k*8 +: 8] = 8'(sel ? 8'h80 + k : k);
      else        v[k*8 +: 8] = 8'(k*73 + p*29 + sel*151 + 11);
    end
    return v;
  endfunction

  task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, capture on the rising edge, sample at the next falling edge.
  task automatic issue(logic v, logic [31:0] w, logic [127:0] a, logic [127:0] b);
    instrValid = v; instrWord = w; srcFirst = a; srcSecond = b;
    @(posedge clk);
    #1 instrValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkQuiet(string req);
    check(!wrEn && !undefFlag, req, {wrEn, undefFlag}, 0);
    check(resultData == lastRes && dstIdx == lastRd, req, resultData, lastRes);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check(!wrEn && !undefFlag && resultData == '0 && dstIdx == '0, "R9", resultData, 0);
    rst_n = 1'b1;
    @(negedge clk);
    lastRes = '0; lastRd = '0;

    // R2 R3 R4 R5 R6: sweep every index in both widths
    for (int p = 0; p < 3; p++) begin
      for (int f = 0; f < 2; f++) begin
        for (int idx = 0; idx < 16; idx++) begin
          logic [127:0] a = mkPat(p, 0);
          logic [127:0] b = mkPat(p, 1);
          logic [4:0] rd = 5'((idx + p * 11) % 32);
          issue(1'b1, mkWord(f[0], idx[3:0], rd, 1'b0, 1'b0, 1'b0), a, b);
          if (f == 0 && idx >= 8) begin
            check(undefFlag && !wrEn, "R6", {wrEn, undefFlag}, 2'b01);
            check(resultData == lastRes && dstIdx == lastRd, "R6 hold", resultData, lastRes);
          end else begin
            lastRes = expWin(a, b, f[0], idx);
            lastRd  = rd;
            check(wrEn && !undefFlag, "R2 write", {wrEn, undefFlag}, 2'b10);
            check(dstIdx == rd, "R2 dstIdx", 128'(dstIdx), 128'(rd));
            check(resultData == lastRes, f ? "R3" : "R4", resultData, lastRes);
            if (idx == 0)
              check(resultData == (f ? a : {64'd0, a[63:0]}), "R5", resultData, a);
            check(shResult == lastRes && shWrEn, "R3 shared", shResult, lastRes);
          end
        end
      end
    end

    // R7: element-move word under both decoder settings
    issue(1'b1, mkWord(1'b1, 4'd5, 5'd9, 1'b1, 1'b0, 1'b0), mkPat(1, 1), mkPat(2, 0));
    check(undefFlag && !wrEn, "R7 sole", {wrEn, undefFlag}, 2'b01);
    check(!shUndef && !shWrEn, "R7 shared", {shWrEn, shUndef}, 2'b00);
    check(resultData == lastRes && dstIdx == lastRd, "R7 hold", resultData, lastRes);

    // R1: bit 15 set and wrong opcode bit are not claimed
    issue(1'b1, mkWord(1'b1, 4'd3, 5'd1, 1'b0, 1'b1, 1'b0), mkPat(1, 0), mkPat(1, 1));
    checkQuiet("R1 bit15");
    issue(1'b1, mkWord(1'b1, 4'd3, 5'd1, 1'b0, 1'b0, 1'b1), mkPat(1, 0), mkPat(1, 1));
    checkQuiet("R1 bit31");
    issue(1'b1, mkWord(1'b1, 4'd3, 5'd1, 1'b0, 1'b0, 1'b0) ^ 32'h0020_0000,
          mkPat(1, 0), mkPat(1, 1));
    checkQuiet("R1 bit21");

    // R8: valid low with an extract word, then pulse ends after one cycle
    issue(1'b0, mkWord(1'b1, 4'd2, 5'd4, 1'b0, 1'b0, 1'b0), mkPat(2, 0), mkPat(2, 1));
    checkQuiet("R8 idle");
    issue(1'b1, mkWord(1'b1, 4'd15, 5'd30, 1'b0, 1'b0, 1'b0), mkPat(0, 0), mkPat(0, 1));
    lastRes = expWin(mkPat(0, 0), mkPat(0, 1), 1'b1, 15); lastRd = 5'd30;
    check(wrEn && resultData == lastRes, "R3 idx15", resultData, lastRes);
    @(negedge clk);
    checkQuiet("R8 pulse");
    check(!(wrEn && undefFlag), "R10", {wrEn, undefFlag}, 0);

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule